// File: doc/BRIEF.md
# Memory Test Program Download Sequencer

This block moves microcoded memory test programs out of an external ROM and into the program registers of a programmable memory self-test controller. The ROM is split into three regions. The first holds the instruction block of every test algorithm. The second holds the data background words that belong to each algorithm. The third holds one descriptor per memory under test, and the memories are gathered into groups. A single start pulse launches the download. The sequencer then runs four nested loops in the order algorithm, background, group and memory. The last word of every memory descriptor is the launch command, so the download stops while that memory is under test. It picks up again when the test engine reports completion.

Each ROM word appears on a write port one cycle after it was read. The write port carries a section code and an index that counts from zero inside each section. When every algorithm has run with every background on every memory, the sequencer returns to idle and raises a completion flag.

Top module: `blr_rom_loader`

## Requirements
- R1: While reset is asserted and directly after it, the block is idle: no ROM read, no register write, no command strobe, busy low and completion flag low.
- R2: A start pulse taken while idle begins fetching at ROM address 0 on the next cycle, with busy high. A start pulse while busy changes nothing in the fetch sequence.
- R3: A word read at a given address in one cycle is written in the next cycle, with the ROM data passed through unchanged. The write index starts at 0 in every section and rises by one per word. The section code is 0 for algorithm words, 1 for background words and 2 for descriptor words.
- R4: ROM layout. Algorithm a starts at a*ALG_LEN. Background b of algorithm a starts at N_ALG*ALG_LEN + (a*N_PAT+b)*PAT_LEN. The descriptor of memory r in group g starts at N_ALG*ALG_LEN + N_ALG*N_PAT*PAT_LEN + (g*N_RAM+r)*DESC_LEN. Every section is read at rising consecutive addresses.
- R5: Once an algorithm's words are fetched, its first background is fetched next, followed by the descriptor of memory 0 in group 0.
- R6: The write of the final descriptor word raises the command strobe for that one cycle. No ROM read then takes place until the test-done input is seen.
- R7: After test-done, the next memory of the same group is fetched. After the last memory of a group, memory 0 of the next group is fetched.
- R8: After the last memory of the last group, the next background of the current algorithm is fetched. After the last background, the next algorithm is fetched.
- R9: After the final test completes, the block goes idle and holds the completion flag high. The next accepted start clears the flag.
- R10: A test-done pulse that arrives while the block is not waiting for a test has no effect on the fetch sequence and does not start a download.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a download |
| test_done_i | input | 1 | Test engine reports the current memory finished |
| rom_rd_o | output | 1 | ROM read enable |
| rom_addr_o | output | ADDR_W | ROM word address |
| rom_data_i | input | DATA_W | ROM read data, valid one cycle after the read |
| wr_en_o | output | 1 | Program register write strobe |
| wr_sec_o | output | 2 | Section code of the word being written |
| wr_idx_o | output | IDX_W | Register index within the section |
| wr_data_o | output | DATA_W | Word being written |
| cmd_wr_o | output | 1 | Final descriptor word is going to the command register |
| busy_o | output | 1 | Download or test in progress |
| done_o | output | 1 | Whole program set has completed |

## Verification
The assertions assume that the ROM answers every read with data in exactly the next cycle. They assume that test-done is a single-cycle pulse given only in response to a command strobe, and that start is a single-cycle pulse. The bench keeps to this with a ROM model that registers a word derived from the address, and with a test-engine model that answers each command strobe after a set delay. Stray test-done pulses and start pulses are placed only inside algorithm fetches or while idle, so the timing the assertions rely on always holds.

// File: rtl/blr_pkg.sv
package blr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALG,
      ST_PAT,
      ST_DESC,
      ST_WAIT
   } state_e;

   localparam logic [1:0] SEC_ALG  = 2'd0;
   localparam logic [1:0] SEC_PAT  = 2'd1;
   localparam logic [1:0] SEC_DESC = 2'd2;

   function automatic int cw(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/blr_step_cnt.sv
module blr_step_cnt
   import blr_pkg::*;
#(
   parameter int LIMIT = 4,
   parameter int W     = cw(LIMIT)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   output logic [W-1:0] val,
   output logic         last
);

   generate
      if (LIMIT > 1) begin : g_count
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (clr)
               q <= '0;
            else if (adv)
               q <= (q == W'(LIMIT - 1)) ? '0 : q + 1'b1;
         end
         assign val  = q;
         assign last = (q == W'(LIMIT - 1));
      end else begin : g_single
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, clr, adv};
         assign val  = '0;
         assign last = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/blr_addr_gen.sv
module blr_addr_gen
   import blr_pkg::*;
#(
   parameter int N_ALG    = 32,
   parameter int N_PAT    = 14,
   parameter int N_GRP    = 64,
   parameter int N_RAM    = 51,
   parameter int ALG_LEN  = 36,
   parameter int PAT_LEN  = 2,
   parameter int DESC_LEN = 10,
   parameter int ADDR_W   = 16,
   parameter int IDX_W    = 6,
   parameter int AW_A     = cw(N_ALG),
   parameter int AW_P     = cw(N_PAT),
   parameter int AW_G     = cw(N_GRP),
   parameter int AW_R     = cw(N_RAM)
) (
   input  logic [1:0]        sec,
   input  logic [AW_A-1:0]   alg,
   input  logic [AW_P-1:0]   pat,
   input  logic [AW_G-1:0]   grp,
   input  logic [AW_R-1:0]   ram,
   input  logic [IDX_W-1:0]  word,
   output logic [ADDR_W-1:0] addr
);

   localparam int PAT_BASE = N_ALG * ALG_LEN;
   localparam int RAM_BASE = PAT_BASE + N_ALG * N_PAT * PAT_LEN;
   localparam int ROM_END  = RAM_BASE + N_GRP * N_RAM * DESC_LEN;

   initial begin
      assert_fit_R4: assert (ROM_END <= (1 << ADDR_W))
         else $error("ROM image of %0d words exceeds address width", ROM_END);
   end

   int base_w;

   always_comb begin
      case (sec)
         SEC_ALG:  base_w = int'(alg) * ALG_LEN;
         SEC_PAT:  base_w = PAT_BASE + (int'(alg) * N_PAT + int'(pat)) * PAT_LEN;
         default:  base_w = RAM_BASE + (int'(grp) * N_RAM + int'(ram)) * DESC_LEN;
      endcase
      addr = ADDR_W'(base_w + int'(word));
   end

endmodule

// File: rtl/blr_wr_pipe.sv
module blr_wr_pipe
   import blr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic [1:0]        sec_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              last_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              wr_en_o,
   output logic [1:0]        wr_sec_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              cmd_wr_o
);

   logic             v_q;
   logic             last_q;
   logic [1:0]       sec_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         last_q <= 1'b0;
         sec_q  <= SEC_ALG;
         idx_q  <= '0;
      end else begin
         v_q    <= rd_i;
         last_q <= rd_i & last_i;
         sec_q  <= sec_i;
         idx_q  <= idx_i;
      end
   end

   assign wr_en_o   = v_q;
   assign wr_sec_o  = sec_q;
   assign wr_idx_o  = idx_q;
   assign wr_data_o = data_i;
   assign cmd_wr_o  = v_q & last_q;

   assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && $past(wr_en_o) && wr_idx_o != '0) |->
         (wr_idx_o == $past(wr_idx_o) + IDX_W'(1) && wr_sec_o == $past(wr_sec_o)));

   assert_cmd_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr_o |-> (wr_sec_o == SEC_DESC));

endmodule

// File: rtl/blr_rom_loader.sv
module blr_rom_loader
   import blr_pkg::*;
#(
   parameter int N_ALG    = 32,
   parameter int N_PAT    = 14,
   parameter int N_GRP    = 64,
   parameter int N_RAM    = 51,
   parameter int ALG_LEN  = 36,
   parameter int PAT_LEN  = 2,
   parameter int DESC_LEN = 10,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 16,
   parameter int IDX_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              test_done_i,
   output logic              rom_rd_o,
   output logic [ADDR_W-1:0] rom_addr_o,
   input  logic [DATA_W-1:0] rom_data_i,
   output logic              wr_en_o,
   output logic [1:0]        wr_sec_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              cmd_wr_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int AW_A    = cw(N_ALG);
   localparam int AW_P    = cw(N_PAT);
   localparam int AW_G    = cw(N_GRP);
   localparam int AW_R    = cw(N_RAM);
   localparam int MAX_LEN = (ALG_LEN > PAT_LEN) ?
                            ((ALG_LEN > DESC_LEN) ? ALG_LEN : DESC_LEN) :
                            ((PAT_LEN > DESC_LEN) ? PAT_LEN : DESC_LEN);

   initial begin
      assert_cfg_counts_R7: assert (N_ALG >= 1 && N_PAT >= 1 && N_GRP >= 1 && N_RAM >= 1)
         else $error("loop counts must be at least one");
      assert_cfg_lens_R3: assert (ALG_LEN >= 1 && PAT_LEN >= 1 && DESC_LEN >= 1 &&
                                  IDX_W >= cw(MAX_LEN) && DATA_W >= 1)
         else $error("section lengths do not fit the index width");
   end

   state_e           state;
   logic [IDX_W-1:0] wcnt;
   logic             done_q;
   logic             wlast;
   logic             launch;
   logic             step;
   logic [1:0]       sec_cur;

   logic [AW_A-1:0]  alg_v;
   logic [AW_P-1:0]  pat_v;
   logic [AW_G-1:0]  grp_v;
   logic [AW_R-1:0]  ram_v;
   logic             alg_last, pat_last, grp_last, ram_last;
   logic             adv_ram, adv_grp, adv_pat, adv_alg;

   assign launch  = (state == ST_IDLE) && start_i;
   assign step    = (state == ST_WAIT) && test_done_i;
   assign adv_ram = step;
   assign adv_grp = adv_ram & ram_last;
   assign adv_pat = adv_grp & grp_last;
   assign adv_alg = adv_pat & pat_last;

   always_comb begin
      case (state)
         ST_ALG:  wlast = (wcnt == IDX_W'(ALG_LEN - 1));
         ST_PAT:  wlast = (wcnt == IDX_W'(PAT_LEN - 1));
         ST_DESC: wlast = (wcnt == IDX_W'(DESC_LEN - 1));
         default: wlast = 1'b0;
      endcase
      case (state)
         ST_ALG:  sec_cur = SEC_ALG;
         ST_PAT:  sec_cur = SEC_PAT;
         default: sec_cur = SEC_DESC;
      endcase
   end

   blr_step_cnt #(.LIMIT(N_ALG)) u_alg (.clk(clk), .rst_n(rst_n), .clr(launch),
      .adv(adv_alg), .val(alg_v), .last(alg_last));
   blr_step_cnt #(.LIMIT(N_PAT)) u_pat (.clk(clk), .rst_n(rst_n), .clr(launch),
      .adv(adv_pat), .val(pat_v), .last(pat_last));
   blr_step_cnt #(.LIMIT(N_GRP)) u_grp (.clk(clk), .rst_n(rst_n), .clr(launch),
      .adv(adv_grp), .val(grp_v), .last(grp_last));
   blr_step_cnt #(.LIMIT(N_RAM)) u_ram (.clk(clk), .rst_n(rst_n), .clr(launch),
      .adv(adv_ram), .val(ram_v), .last(ram_last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         wcnt   <= '0;
         done_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start_i) begin
               state  <= ST_ALG;
               wcnt   <= '0;
               done_q <= 1'b0;
            end
            ST_ALG: if (wlast) begin
               wcnt  <= '0;
               state <= ST_PAT;
            end else wcnt <= wcnt + 1'b1;
            ST_PAT: if (wlast) begin
               wcnt  <= '0;
               state <= ST_DESC;
            end else wcnt <= wcnt + 1'b1;
            ST_DESC: if (wlast) begin
               wcnt  <= '0;
               state <= ST_WAIT;
            end else wcnt <= wcnt + 1'b1;
            ST_WAIT: if (test_done_i) begin
               if (!(ram_last && grp_last))
                  state <= ST_DESC;
               else if (!pat_last)
                  state <= ST_PAT;
               else if (!alg_last)
                  state <= ST_ALG;
               else begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rom_rd_o = (state == ST_ALG) || (state == ST_PAT) || (state == ST_DESC);
   assign busy_o   = (state != ST_IDLE);
   assign done_o   = done_q;

   blr_addr_gen #(
      .N_ALG(N_ALG), .N_PAT(N_PAT), .N_GRP(N_GRP), .N_RAM(N_RAM),
      .ALG_LEN(ALG_LEN), .PAT_LEN(PAT_LEN), .DESC_LEN(DESC_LEN),
      .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) u_addr (
      .sec(sec_cur), .alg(alg_v), .pat(pat_v), .grp(grp_v), .ram(ram_v),
      .word(wcnt), .addr(rom_addr_o)
   );

   blr_wr_pipe #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pipe (
      .clk(clk), .rst_n(rst_n), .rd_i(rom_rd_o), .sec_i(sec_cur), .idx_i(wcnt),
      .last_i(wlast && state == ST_DESC), .data_i(rom_data_i),
      .wr_en_o(wr_en_o), .wr_sec_o(wr_sec_o), .wr_idx_o(wr_idx_o),
      .wr_data_o(wr_data_o), .cmd_wr_o(cmd_wr_o)
   );

   assert_rd_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd_o |=> wr_en_o);

   assert_no_rd_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_rd_o |=> !wr_en_o);

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd_o && wcnt != '0) |-> (rom_addr_o == $past(rom_addr_o) + ADDR_W'(1)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !test_done_i) |=> (state == ST_WAIT && !rom_rd_o));

   assert_cmd_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr_o |-> (state == ST_WAIT));

   assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> !(rom_rd_o && rom_addr_o == '0));

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

endmodule

// File: tb/tb_blr_rom_loader.sv
module tb_blr_rom_loader;

   localparam int N_ALG    = 2;
   localparam int N_PAT    = 2;
   localparam int N_GRP    = 2;
   localparam int N_RAM    = 3;
   localparam int ALG_LEN  = 4;
   localparam int PAT_LEN  = 2;
   localparam int DESC_LEN = 3;
   localparam int DATA_W   = 32;
   localparam int ADDR_W   = 6;
   localparam int IDX_W    = 2;
   localparam int PB       = N_ALG * ALG_LEN;
   localparam int RB       = PB + N_ALG * N_PAT * PAT_LEN;
   localparam int NW       = N_ALG * (ALG_LEN + N_PAT * (PAT_LEN + N_GRP * N_RAM * DESC_LEN));

   typedef struct packed {
      logic [7:0] dly;
      logic       stray;
      logic       early;
   } run_t;

   localparam run_t RUNS [4] = '{
      '{8'd1, 1'b0, 1'b0},
      '{8'd5, 1'b0, 1'b1},
      '{8'd2, 1'b1, 1'b0},
      '{8'd9, 1'b1, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              extra_done = 1'b0;
   logic              eng_done;
   logic              test_done;
   logic              rom_rd;
   logic [ADDR_W-1:0] rom_addr;
   logic [DATA_W-1:0] rom_q;
   logic              wr_en, cmd_wr, busy, done;
   logic [1:0]        wr_sec;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_data;

   assign test_done = eng_done | extra_done;

   always #4 clk = ~clk;

   blr_rom_loader #(
      .N_ALG(N_ALG), .N_PAT(N_PAT), .N_GRP(N_GRP), .N_RAM(N_RAM),
      .ALG_LEN(ALG_LEN), .PAT_LEN(PAT_LEN), .DESC_LEN(DESC_LEN),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .test_done_i(test_done),
      .rom_rd_o(rom_rd), .rom_addr_o(rom_addr), .rom_data_i(rom_q),
      .wr_en_o(wr_en), .wr_sec_o(wr_sec), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
      .cmd_wr_o(cmd_wr), .busy_o(busy), .done_o(done)
   );

   function automatic logic [DATA_W-1:0] romf(input int a);
      return {16'hB157, 16'(a)};
   endfunction

   // ROM model: one cycle read latency
   always_ff @(posedge clk)
      if (rom_rd) rom_q <= romf(int'(rom_addr));

   // test engine model: answers each command strobe after eng_dly cycles
   int eng_dly = 1;
   int eng_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_cnt  <= 0;
         eng_done <= 1'b0;
      end else begin
         eng_done <= 1'b0;
         if (cmd_wr) eng_cnt <= eng_dly;
         else if (eng_cnt != 0) begin
            eng_cnt <= eng_cnt - 1;
            if (eng_cnt == 1) eng_done <= 1'b1;
         end
      end
   end

   // expected write sequence derived from the layout in R4 and the loop order of R5, R7, R8
   int       exp_addr [NW];
   int       exp_idx  [NW];
   int       exp_sec  [NW];
   bit       exp_last [NW];

   // monitor
   bit mon_on = 1'b0;
   int mon_p = 0;
   int mon_checks = 0;
   int mon_fails = 0;
   int lat_err = 0;
   int wait_err = 0;
   bit waiting = 1'b0;
   bit prev_rd = 1'b0;

   always @(negedge clk) begin
      if (!mon_on) begin
         prev_rd = 1'b0;
         waiting = 1'b0;
      end else begin
         if (start_i && !busy) mon_p = 0;
         if (wr_en != prev_rd) lat_err++;
         prev_rd = rom_rd;
         if (cmd_wr) waiting = 1'b1;
         if (waiting && rom_rd) wait_err++;
         if (test_done) waiting = 1'b0;
         if (wr_en) begin
            if (mon_p < NW) begin
               mon_checks++;
               if (wr_data !== romf(exp_addr[mon_p])) begin
                  mon_fails++;
                  $display("FAIL R4 R5 R7 R8 word %0d data actual=%h expected=%h",
                           mon_p, wr_data, romf(exp_addr[mon_p]));
               end
               mon_checks++;
               if (int'(wr_idx) != exp_idx[mon_p] || int'(wr_sec) != exp_sec[mon_p]) begin
                  mon_fails++;
                  $display("FAIL R3 word %0d idx/sec actual=%0d/%0d expected=%0d/%0d",
                           mon_p, wr_idx, wr_sec, exp_idx[mon_p], exp_sec[mon_p]);
               end
               mon_checks++;
               if (cmd_wr !== exp_last[mon_p]) begin
                  mon_fails++;
                  $display("FAIL R6 word %0d cmd actual=%0d expected=%0d",
                           mon_p, cmd_wr, exp_last[mon_p]);
               end
            end else begin
               mon_checks++;
               mon_fails++;
               $display("FAIL R8 extra write actual=%0d expected=%0d", mon_p + 1, NW);
            end
            mon_p++;
         end
      end
   end

   int checks = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_run(input run_t r);
      eng_dly = int'(r.dly);
      tick();
      start_i = 1'b1;
      tick();
      start_i = 1'b0;
      chk(rom_rd == 1'b1 && rom_addr == '0, "R2 first read at address 0", int'(rom_addr), 0);
      chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      chk(done == 1'b0, "R9 flag cleared by start", int'(done), 0);
      tick();
      extra_done = r.stray;          // R10 stray done during algorithm fetch
      tick();
      extra_done = 1'b0;
      start_i = r.early;             // R2 start while busy
      tick();
      start_i = 1'b0;
      for (int k = 0; k < 5000; k++) begin
         if (done) break;
         tick();
      end
      chk(mon_p == NW, "R2 R10 R8 complete write count", mon_p, NW);
      chk(done == 1'b1 && busy == 1'b0, "R9 idle with flag", int'(done), 1);
      repeat (5) tick();
      chk(done == 1'b1 && busy == 1'b0, "R9 flag held", int'(done), 1);
   endtask

   initial begin
      int k = 0;
      for (int a = 0; a < N_ALG; a++) begin
         for (int w = 0; w < ALG_LEN; w++) begin
            exp_addr[k] = a * ALG_LEN + w; exp_idx[k] = w; exp_sec[k] = 0; exp_last[k] = 1'b0; k++;
         end
         for (int b = 0; b < N_PAT; b++) begin
            for (int w = 0; w < PAT_LEN; w++) begin
               exp_addr[k] = PB + (a * N_PAT + b) * PAT_LEN + w;
               exp_idx[k] = w; exp_sec[k] = 1; exp_last[k] = 1'b0; k++;
            end
            for (int g = 0; g < N_GRP; g++)
               for (int m = 0; m < N_RAM; m++)
                  for (int w = 0; w < DESC_LEN; w++) begin
                     exp_addr[k] = RB + (g * N_RAM + m) * DESC_LEN + w;
                     exp_idx[k] = w; exp_sec[k] = 2; exp_last[k] = (w == DESC_LEN - 1); k++;
                  end
         end
      end

      // R1 reset state
      repeat (3) tick();
      chk(!rom_rd && !wr_en && !cmd_wr, "R1 no access in reset", int'(rom_rd), 0);
      chk(!busy && !done, "R1 idle in reset", int'(busy), 0);
      rst_n = 1'b1;
      tick();
      mon_on = 1'b1;
      chk(!rom_rd && !busy && !done, "R1 idle after reset", int'(busy), 0);

      // R10 stray done while idle
      extra_done = 1'b1;
      tick();
      extra_done = 1'b0;
      tick();
      chk(!busy && !rom_rd, "R10 done while idle ignored", int'(busy), 0);

      // table of runs
      for (int i = 0; i < 4; i++) do_run(RUNS[i]);
      chk(lat_err == 0, "R3 one cycle read to write latency", lat_err, 0);
      chk(wait_err == 0, "R6 no reads while a test runs", wait_err, 0);

      // R1 reset in the middle of a download
      tick();
      start_i = 1'b1;
      tick();
      start_i = 1'b0;
      repeat (30) tick();
      mon_on = 1'b0;
      rst_n = 1'b0;
      #1;
      chk(!rom_rd && !wr_en && !cmd_wr && !busy && !done, "R1 mid-run reset", int'(busy), 0);
      tick();
      rst_n = 1'b1;
      repeat (20) tick();
      chk(!busy && !rom_rd, "R1 stays idle after reset", int'(busy), 0);
      mon_on = 1'b1;
      do_run(RUNS[0]);
      chk(lat_err == 0 && wait_err == 0, "R6 R3 after recovery", lat_err + wait_err, 0);

      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + mon_checks, fails + mon_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
   end

endmodule